// File: doc/BRIEF.md
# Tiled Sign-Weight Matrix-Vector Engine

This block forms the local field of every spin in an Ising problem, h_i = sum over j of J_ij * x_j. The spin amplitudes x_j are signed fixed-point numbers. Every coupling J_ij is either +1 or -1 and is stored as a single bit. A product therefore needs no multiplier: each term is the amplitude or its two's-complement negation. The matrix is cut into square tiles of U rows by U columns. One U-wide row segment enters a registered adder tree every cycle. The tree's root sums are added into one accumulator per row of the current row tile.

The engine reads its coupling words from a synchronous memory outside the block, one U-bit word per cycle. The host holds the amplitude vector steady on a flat bus and pulses a start strobe. The engine then walks every tile. For each row tile it visits the column tiles in turn, and inside each column tile it visits the rows of that tile. When the last column tile of a row tile has been added, that tile's h values leave the block in ascending index order, each with a valid strobe. A one-cycle done pulse closes the product.

Top module: `binmv_engine`

## Requirements
- R1: While reset is held and after it is released, hValid, done, busy and wRdEn stay low until start is accepted.
- R2: Each result equals the sum over j < N of s_ij * x_j, where s_ij is +1 for a weight bit of 1 and -1 for a bit of 0. The word at address i*T + c, with T = ceil(N/U), holds in bit b the weight of row i and column c*U + b. wData must carry that word in the cycle after wRdEn presents wAddr.
- R3: hOut is XW + ceil(log2 N) + 1 bits wide. Results are exact at the range extremes, including the negation of the most negative amplitude (N=10, XW=8: 1270, 1280 and -1280).
- R4: Weight bits whose column index c*U + b is N or above have no effect on any result.
- R5: A product emits exactly N results, with hIdx running 0, 1, ..., N-1 in that order.
- R6: done is high for exactly one cycle, in the cycle right after the valid that carries index N-1.
- R7: busy is high from the edge that accepts start until the done cycle. A start pulse while busy is high is ignored and changes neither the results, nor their count, nor the read sequence.
- R8: The engine issues one read per cycle. Row tiles form the outer loop, column tiles the middle loop and rows within a tile the inner loop. Rows N and above are never read, so a product makes N*T reads.
- R9: done rises N*T + log2(U) + 3 cycles after the clock edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a product when the engine is idle |
| xVec | input | N*XW | Signed amplitudes; x_j sits at bits j*XW upward |
| wData | input | U | Coupling word returned by the memory one cycle after the read |
| wAddr | output | ceil(log2(N*T)) | Coupling word address |
| wRdEn | output | 1 | Read strobe for wAddr |
| busy | output | 1 | A product is in progress |
| hValid | output | 1 | hOut and hIdx carry a finished field |
| hIdx | output | ceil(log2 N) | Row index of the result |
| hOut | output | XW+ceil(log2 N)+1 | Signed local field |
| done | output | 1 | One-cycle end-of-product pulse |

## Verification
The bench uses a matrix of N = 10 with U = 4, so the last tile has two rows and two padding columns with no spin behind them. It sets those padding bits to 1 and also fills them at random. A design that failed to zero the unused leaves would then show errors in every row. Products with all amplitudes at +127 or at -128, and all weights set the same way, expose a sign or width fault: a narrow accumulator wraps, and a wrong negation of -128 gives -128 back. The bench compares the full address trace against the tile walk and measures the cycle count from start to done. A swapped loop order, an extra or missing read, or a pipeline stage off by one changes one of these results. A start pulse issued mid-product shows whether a restart is wrongly accepted.

// File: rtl/binmv_pkg.sv
`timescale 1ns/1ps
package binmv_pkg;

  // Per-read strobes sent from the walker to the datapath.
  typedef struct packed {
    logic issue;     // a coupling word is being read this cycle
    logic firstCol;  // first column tile of the row: clear the accumulator
    logic lastCol;   // last column tile of the row: result is final
    logic lastAll;   // final read of the whole product
  } mvStrobe_t;

endpackage

// File: rtl/binmv_ctrl.sv
`timescale 1ns/1ps
module binmv_ctrl
  import binmv_pkg::*;
#(
  parameter int N = 10,
  parameter int U = 4,
  localparam int NT = (N + U - 1) / U,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int KW = (U > 1) ? $clog2(U) : 1,
  localparam int CW = (NT > 1) ? $clog2(NT) : 1,
  localparam int AW = (N * NT > 1) ? $clog2(N * NT) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          pipeBusy,
  output mvStrobe_t     strobe,
  output logic [IW-1:0] rowIdx,
  output logic [KW-1:0] kIdx,
  output logic [CW-1:0] colTile,
  output logic [AW-1:0] wAddr,
  output logic          running
);

  localparam int LASTROWS = N - (NT - 1) * U;

  typedef enum logic {S_IDLE, S_RUN} ctlState_t;
  ctlState_t st;

  logic [CW-1:0] rt, ct;
  logic [KW-1:0] k;
  logic lastRt, lastCt, lastK;

  assign lastRt = (rt == CW'(NT - 1));
  assign lastCt = (ct == CW'(NT - 1));
  assign lastK  = lastRt ? (k == KW'(LASTROWS - 1)) : (k == KW'(U - 1));

  // Walk: row tile outer, column tile middle, row inside tile inner.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE;
      rt <= '0;
      ct <= '0;
      k  <= '0;
    end else if (st == S_IDLE) begin
      if (start && !pipeBusy) begin
        st <= S_RUN;
        rt <= '0;
        ct <= '0;
        k  <= '0;
      end
    end else begin
      if (!lastK) begin
        k <= k + 1'b1;
      end else begin
        k <= '0;
        if (!lastCt) begin
          ct <= ct + 1'b1;
        end else begin
          ct <= '0;
          if (!lastRt) rt <= rt + 1'b1;
          else         st <= S_IDLE;
        end
      end
    end
  end

  assign running         = (st == S_RUN);
  assign strobe.issue    = (st == S_RUN);
  assign strobe.firstCol = (ct == '0);
  assign strobe.lastCol  = lastCt;
  assign strobe.lastAll  = lastCt && lastRt && lastK;

  assign rowIdx  = IW'(32'(rt) * U + 32'(k));
  assign kIdx    = k;
  assign colTile = ct;
  assign wAddr   = AW'(32'(rowIdx) * NT + 32'(ct));

  // R8: every read falls inside the coupling memory
  p_addr_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> (32'(wAddr) < N * NT))
    else $error("read address outside the coupling memory");

  // R8: after the last row of a tile, the column tile advances and the row tile stays
  p_tile_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && lastK && !lastCt) |=>
      (k == '0 && ct == $past(ct) + 1'b1 && rt == $past(rt)))
    else $error("column tile did not advance");

  // R7: a product in flight is never restarted
  p_restart_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !strobe.lastAll) |=>
      (strobe.issue && !(rt == '0 && ct == '0 && k == '0)))
    else $error("walk restarted mid-product");

endmodule

// File: rtl/binmv_datapath.sv
`timescale 1ns/1ps
module binmv_datapath
  import binmv_pkg::*;
#(
  parameter int N  = 10,
  parameter int U  = 4,
  parameter int XW = 8,
  localparam int NT = (N + U - 1) / U,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int KW = (U > 1) ? $clog2(U) : 1,
  localparam int CW = (NT > 1) ? $clog2(NT) : 1,
  localparam int HW = XW + 1 + $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mvStrobe_t            strobe,
  input  logic [IW-1:0]        rowIdx,
  input  logic [KW-1:0]        kIdx,
  input  logic [CW-1:0]        colTile,
  input  logic [N*XW-1:0]      xVec,
  input  logic [U-1:0]         wData,
  output logic                 hValid,
  output logic [IW-1:0]        hIdx,
  output logic signed [HW-1:0] hOut,
  output logic                 done,
  output logic                 pipeBusy
);

  localparam int LG    = $clog2(U);
  localparam int STG   = LG + 2;       // memory stage + leaf stage + tree levels
  localparam int NODES = 2 * U - 1;
  localparam int BOUND = U * (2 ** (XW - 1));

  // Amplitude unpack
  logic signed [XW-1:0] xArr [N];
  for (genvar j = 0; j < N; j++) begin : g_unpack
    assign xArr[j] = $signed(xVec[j*XW +: XW]);
  end

  // Strobe/index pipeline aligned with the data
  mvStrobe_t     sPipe [STG];
  logic [IW-1:0] iPipe [STG];
  logic [KW-1:0] kPipe [STG];
  logic [CW-1:0] ctQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STG; s++) begin
        sPipe[s] <= '0;
        iPipe[s] <= '0;
        kPipe[s] <= '0;
      end
      ctQ <= '0;
    end else begin
      sPipe[0] <= strobe;
      iPipe[0] <= rowIdx;
      kPipe[0] <= kIdx;
      ctQ      <= colTile;
      for (int s = 1; s < STG; s++) begin
        sPipe[s] <= sPipe[s-1];
        iPipe[s] <= iPipe[s-1];
        kPipe[s] <= kPipe[s-1];
      end
    end
  end

  // Leaf terms: +x, -x, or zero for padding columns
  logic [U-1:0][HW-1:0] leafD;
  for (genvar b = 0; b < U; b++) begin : g_leaf
    logic [31:0]          colIdx;
    logic                 inRange;
    logic [31:0]          colSafe;
    logic signed [HW-1:0] xExt;
    assign colIdx  = 32'(ctQ) * U + b;
    assign inRange = sPipe[0].issue && (colIdx < N);
    assign colSafe = inRange ? colIdx : 32'd0;
    assign xExt    = HW'(xArr[IW'(colSafe)]);
    assign leafD[b] = !inRange ? '0 : (wData[b] ? xExt : -xExt);
  end

  // Registered adder tree in heap order: leaves at U-1.., root at 0
  logic signed [HW-1:0] node [NODES];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < NODES; n++) node[n] <= '0;
    end else begin
      for (int n = 0; n < U - 1; n++) node[n] <= node[2*n+1] + node[2*n+2];
      for (int b = 0; b < U; b++)     node[U-1+b] <= $signed(leafD[b]);
    end
  end

  // Accumulation across column tiles
  mvStrobe_t            sL;
  logic [IW-1:0]        iL;
  logic [KW-1:0]        kL;
  logic signed [HW-1:0] acc [U];
  logic signed [HW-1:0] sumNow;
  logic                 lastQ;

  assign sL     = sPipe[STG-1];
  assign iL     = iPipe[STG-1];
  assign kL     = kPipe[STG-1];
  assign sumNow = (sL.firstCol ? '0 : acc[kL]) + node[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < U; r++) acc[r] <= '0;
      hValid <= 1'b0;
      hIdx   <= '0;
      hOut   <= '0;
      lastQ  <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (sL.issue) acc[kL] <= sumNow;
      hValid <= sL.issue && sL.lastCol;
      if (sL.issue && sL.lastCol) begin
        hOut <= sumNow;
        hIdx <= iL;
      end
      lastQ <= sL.issue && sL.lastAll;
      done  <= lastQ;
    end
  end

  always_comb begin
    pipeBusy = lastQ;
    for (int s = 0; s < STG; s++) pipeBusy = pipeBusy | sPipe[s].issue;
  end

  // Checker state for the ordering property
  logic [IW-1:0] nextIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       nextIdx <= '0;
    else if (hValid) nextIdx <= (hIdx == IW'(N - 1)) ? '0 : hIdx + 1'b1;
  end

  // R3: a tree root never exceeds U full-scale terms
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    sL.issue |-> (node[0] <= BOUND && node[0] >= -BOUND))
    else $error("tree root out of range");

  // R5: results leave in ascending index order
  p_index_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    hValid |-> (hIdx == nextIdx))
    else $error("result index out of order");

  // R6: done follows the valid of the last index
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(hValid) && hIdx == IW'(N - 1)))
    else $error("done without a preceding final valid");

  // R6: done lasts one cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done)
    else $error("done longer than one cycle");

endmodule

// File: rtl/binmv_engine.sv
`timescale 1ns/1ps
module binmv_engine
  import binmv_pkg::*;
#(
  parameter int N  = 10,
  parameter int U  = 4,
  parameter int XW = 8,
  localparam int NT = (N + U - 1) / U,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = (N * NT > 1) ? $clog2(N * NT) : 1,
  localparam int HW = XW + 1 + $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [N*XW-1:0]      xVec,
  input  logic [U-1:0]         wData,
  output logic [AW-1:0]        wAddr,
  output logic                 wRdEn,
  output logic                 busy,
  output logic                 hValid,
  output logic [IW-1:0]        hIdx,
  output logic signed [HW-1:0] hOut,
  output logic                 done
);

  localparam int KW = (U > 1) ? $clog2(U) : 1;
  localparam int CW = (NT > 1) ? $clog2(NT) : 1;

  mvStrobe_t     strobe;
  logic [IW-1:0] rowIdx;
  logic [KW-1:0] kIdx;
  logic [CW-1:0] colTile;
  logic          running;
  logic          pipeBusy;

  binmv_ctrl #(.N(N), .U(U)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .pipeBusy (pipeBusy),
    .strobe   (strobe),
    .rowIdx   (rowIdx),
    .kIdx     (kIdx),
    .colTile  (colTile),
    .wAddr    (wAddr),
    .running  (running)
  );

  binmv_datapath #(.N(N), .U(U), .XW(XW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rowIdx   (rowIdx),
    .kIdx     (kIdx),
    .colTile  (colTile),
    .xVec     (xVec),
    .wData    (wData),
    .hValid   (hValid),
    .hIdx     (hIdx),
    .hOut     (hOut),
    .done     (done),
    .pipeBusy (pipeBusy)
  );

  assign wRdEn = strobe.issue;
  assign busy  = running | pipeBusy;

endmodule

// File: tb/binmv_engine_test.sv
`timescale 1ns/1ps
module binmv_engine_test;

  localparam int N  = 10;
  localparam int U  = 4;
  localparam int XW = 8;
  localparam int NT = (N + U - 1) / U;
  localparam int IW = $clog2(N);
  localparam int AW = $clog2(N * NT);
  localparam int HW = XW + 1 + $clog2(N);
  localparam int NW = N * NT;
  localparam int LG = $clog2(U);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N*XW-1:0] xVec = '0;
  logic [U-1:0] wData = '0;
  logic [AW-1:0] wAddr;
  logic wRdEn, busy, hValid, done;
  logic [IW-1:0] hIdx;
  logic signed [HW-1:0] hOut;

  binmv_engine #(.N(N), .U(U), .XW(XW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .xVec(xVec), .wData(wData),
    .wAddr(wAddr), .wRdEn(wRdEn), .busy(busy), .hValid(hValid),
    .hIdx(hIdx), .hOut(hOut), .done(done)
  );

  always #4 clk = ~clk;

  // Coupling memory: one-cycle synchronous read
  logic [U-1:0] mem [NW];
  always @(posedge clk) wData <= (32'(wAddr) < NW) ? mem[wAddr] : '0;

  logic signed [XW-1:0] xv [N];

  int nChecks = 0, nFail = 0;
  int gotH [64];
  int gotIdx [64];
  int addrLog [64];
  int gotCnt = 0, aCnt = 0, doneCnt = 0, doneBad = 0;
  bit prevValid = 0;
  int prevIdx = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (hValid && gotCnt < 64) begin
        gotH[gotCnt] = int'(hOut);
        gotIdx[gotCnt] = int'(hIdx);
        gotCnt++;
      end
      if (wRdEn && aCnt < 64) begin
        addrLog[aCnt] = int'(wAddr);
        aCnt++;
      end
      if (done) begin
        doneCnt++;
        if (!prevValid || prevIdx != N - 1) doneBad++;
      end
      prevValid = hValid;
      prevIdx = int'(hIdx);
    end
  end

  task automatic check(input string what, input bit ok, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int expH(input int i);
    int s = 0;
    for (int j = 0; j < N; j++) begin
      if (mem[i*NT + j/U][j%U]) s += int'(xv[j]);
      else                      s -= int'(xv[j]);
    end
    return s;
  endfunction

  task automatic fillMem(input int mode);
    for (int a = 0; a < NW; a++) begin
      case (mode)
        0: mem[a] = '0;
        1: mem[a] = '1;
        2: mem[a] = U'($urandom);
        default: mem[a] = '0;
      endcase
    end
  endtask

  // R4 helper: force padding-column bits to a chosen value
  task automatic setPads(input bit v);
    for (int i = 0; i < N; i++)
      for (int b = 0; b < U; b++)
        if ((NT - 1) * U + b >= N) mem[i*NT + NT - 1][b] = v;
  endtask

  task automatic runProduct(input bit extraStart, input string tag);
    int cyc;
    int idx;
    int addrErr;
    bit busySeen;
    for (int j = 0; j < N; j++) xVec[j*XW +: XW] = xv[j];
    gotCnt = 0; aCnt = 0; doneCnt = 0; doneBad = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    busySeen = busy;
    cyc = 0;
    while (!done && cyc < 300) begin
      @(posedge clk);
      #1;
      cyc++;
      start = (extraStart && cyc == 4) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);

    check({tag, " R7 busy after start"}, busySeen == 1'b1, int'(busySeen), 1);
    check({tag, " R9 start-to-done cycles"}, cyc == N*NT + LG + 3, cyc, N*NT + LG + 3);
    check({tag, " R5 result count"}, gotCnt == N, gotCnt, N);
    for (int r = 0; r < N && r < gotCnt; r++) begin
      check({tag, " R5 index order"}, gotIdx[r] == r, gotIdx[r], r);
      check({tag, " R2 R3 R4 field value"}, gotH[r] == expH(r), gotH[r], expH(r));
    end
    check({tag, " R6 done pulse count"}, doneCnt == 1, doneCnt, 1);
    check({tag, " R6 done after last valid"}, doneBad == 0, doneBad, 0);
    check({tag, " R8 read count"}, aCnt == N*NT, aCnt, N*NT);
    idx = 0; addrErr = 0;
    for (int rt = 0; rt < NT; rt++)
      for (int ct = 0; ct < NT; ct++)
        for (int k = 0; k < U; k++)
          if (rt*U + k < N) begin
            if (idx < aCnt && addrLog[idx] != (rt*U + k)*NT + ct) addrErr++;
            idx++;
          end
    check({tag, " R8 read order"}, addrErr == 0, addrErr, 0);
    check({tag, " R7 idle after done"}, busy == 1'b0, int'(busy), 0);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240917);
    fillMem(0);
    for (int j = 0; j < N; j++) xv[j] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 hValid in reset", hValid == 1'b0, int'(hValid), 0);
    check("R1 done in reset", done == 1'b0, int'(done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 busy after reset", busy == 1'b0, int'(busy), 0);
    check("R1 wRdEn after reset", wRdEn == 1'b0, int'(wRdEn), 0);

    // R3: all +1, largest positive amplitude
    for (int j = 0; j < N; j++) xv[j] = 8'sd127;
    fillMem(1); setPads(1'b0);
    runProduct(1'b0, "max-pos");

    // R3 R4: all -1 on the most negative amplitude, padding bits set
    for (int j = 0; j < N; j++) xv[j] = -8'sd128;
    fillMem(0); setPads(1'b1);
    runProduct(1'b0, "neg-neg");

    // R3: all +1 on the most negative amplitude
    fillMem(1);
    runProduct(1'b0, "pos-neg");

    // R2: checkerboard weights, ramp amplitudes
    for (int j = 0; j < N; j++) xv[j] = XW'(j - 5);
    for (int i = 0; i < N; i++)
      for (int c = 0; c < NT; c++)
        for (int b = 0; b < U; b++) mem[i*NT + c][b] = ((i + c*U + b) % 2) == 1;
    runProduct(1'b0, "checker");

    // R7: start pulse mid-product
    fillMem(2);
    for (int j = 0; j < N; j++) xv[j] = XW'($urandom);
    runProduct(1'b1, "restart-ignored");

    // R2 R4: constrained random products
    for (int t = 0; t < 8; t++) begin
      fillMem(2);
      for (int j = 0; j < N; j++) xv[j] = XW'($urandom);
      runProduct(1'b0, "random");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule